// File: doc/BRIEF.md
# Buffered Serial Transmitter

This block turns bytes written by a host into asynchronous serial frames on a single output line. Each write lands in a holding stage. That stage is either a 16-deep first-in first-out queue or, with the queue disabled, a one-byte register. A shift engine then sends each byte as a frame. The frame has a low start bit, 5 to 8 data bits with the least significant bit first, an optional odd or even parity bit, and one or two high stop bits. An external bit-rate tick times the shift engine. A two-bit field sets how many ticks make up one serial bit: 16, 8 or 4.

The shift engine is a five-state machine. The states are IDLE, START, DATA, PARITY and STOP, and the transitions are these:
- IDLE goes to START when a byte is waiting, and takes that byte.
- START goes to DATA when the start bit's tick count ends.
- DATA stays in DATA until the last configured data bit ends. It then goes to PARITY if parity is on, or to STOP if it is off.
- PARITY goes to STOP when the parity bit ends.
- STOP stays in STOP while a second stop bit is due. At the end of the last stop bit it goes straight to START if another byte is waiting, or to IDLE if none is.

The block has two status outputs. The host watches the holding-empty flag and the line-idle flag to pace its writes. It also watches a transmit-empty interrupt that it can mask. Configuration inputs are expected to stay stable while a frame is in flight.

Top module: `uart_tx_core`

## Requirements
- R1: After reset, `txd` is 1, `thr_empty` is 1, `tx_idle` is 1 and `irq` is 0.
- R2: Every serial bit lasts a fixed number of `bit_tick` pulses, set by `cfg_ratio`: code 0 gives 16, code 1 gives 8, code 2 gives 4 and code 3 gives 16.
- R3: A frame starts with one bit at 0, then sends the data bits least significant first. The number of data bits is 5 plus `cfg_len`, so codes 0 to 3 give 5 to 8 bits. Data bits above that count are not sent.
- R4: When `cfg_par_en` is 1, a parity bit follows the data bits. It is computed over the sent data bits only. With `cfg_par_odd` at 0 the total count of ones in data plus parity is even; with `cfg_par_odd` at 1 it is odd.
- R5: A frame ends with one stop bit at 1, or with two when `cfg_two_stop` is 1. The line rests at 1 when nothing is sent.
- R6: With `cfg_fifo_en` at 1, the queue holds up to 16 bytes and sends them in the order written. A write that arrives while 16 bytes are queued is discarded.
- R7: With `cfg_fifo_en` at 0, one byte can be held. `thr_empty` goes to 1 in the cycle after the held byte moves into the shift engine. A write that arrives while a byte is held is discarded.
- R8: With the queue enabled, `thr_empty` is 1 exactly when the queue holds no byte, even while the shift engine is still sending.
- R9: `tx_idle` is 1 only when the shift engine is in IDLE and nothing is waiting in the holding stage.
- R10: When a byte is waiting at the end of the last stop bit, its start bit begins on the next cycle. No idle time is inserted between the two frames.
- R11: `irq` equals `cfg_irq_en` AND `thr_empty`. Setting the enable while the holding stage is empty raises `irq` in the same cycle. An accepted write drops `irq` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | Oversampling tick, one cycle per pulse |
| cfg_ratio | input | 2 | Ticks per bit select (0:16, 1:8, 2:4, 3:16) |
| cfg_len | input | 2 | Data bits minus 5 |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 even |
| cfg_two_stop | input | 1 | 1 sends two stop bits |
| cfg_fifo_en | input | 1 | 1 selects the 16-deep queue, 0 the single holding byte |
| cfg_irq_en | input | 1 | Transmit-empty interrupt enable |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Byte to send |
| txd | output | 1 | Serial output line |
| thr_empty | output | 1 | Holding stage empty |
| tx_idle | output | 1 | Holding stage empty and shift engine idle |
| irq | output | 1 | Transmit-empty interrupt |

## Verification
Random bursts vary the ratio, length, parity mode, stop count and tick spacing. They separate errors in bit ordering, masking and parity from errors in timing. Bursts with a tick on every cycle also measure the spacing from one start bit to the next, which catches any idle gap inserted between frames.

Directed runs cover several cases:
- a byte of all ones per ratio code, so the length of the low start bit alone reveals the tick count;
- a 20-byte burst, which shows where the queue stops accepting;
- a three-write sequence in single-byte mode, which shows when the holding flag flips and that the third byte is dropped;
- an enable toggle while empty, which shows the interrupt gating and how a write clears it.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PARITY,
        S_STOP
    } tx_state_t;

    function automatic logic [4:0] bit_ticks(input logic [1:0] code);
        logic [4:0] n;
        unique case (code)
            2'd1:    n = 5'd8;
            2'd2:    n = 5'd4;
            default: n = 5'd16;
        endcase
        return n;
    endfunction

    function automatic logic [3:0] data_bits(input logic [1:0] code);
        return 4'd5 + {2'b00, code};
    endfunction

    function automatic logic [DATA_W-1:0] data_mask(input logic [1:0] code);
        return {DATA_W{1'b1}} >> (2'd3 - code);
    endfunction

endpackage

// File: rtl/uart_tx_buffer.sv
module uart_tx_buffer #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fifo_en,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] count;
    logic          push, pop;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (count == '0);
    assign full    = fifo_en ? (count == CW'(DEPTH)) : !empty;
    assign push    = wr_en && !full;
    assign pop     = rd_en && !empty;
    assign rd_data = mem[rptr];

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= step(wptr);
            if (pop)  rptr <= step(rptr);
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    p_single_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |-> count <= CW'(1));
    p_pop_nonempty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty);

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
    import uart_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [1:0]        ratio,
    input  logic [1:0]        len,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              two_stop,
    input  logic              avail,
    input  logic [DATA_W-1:0] data,
    output logic              pop,
    output logic              txd,
    output logic              busy
);
    localparam int IW = $clog2(DATA_W) + 1;

    tx_state_t         state, state_nx;
    logic [4:0]        tick_cnt, tick_lim;
    logic [IW-1:0]     bit_idx, nbits;
    logic [DATA_W-1:0] shreg;
    logic              par_q, stop_q;
    logic              bit_end, last_stop;

    assign tick_lim  = bit_ticks(ratio);
    assign nbits     = IW'(data_bits(len));
    assign bit_end   = tick && (tick_cnt == tick_lim - 5'd1);
    assign last_stop = (stop_q == two_stop);
    assign busy      = (state != S_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        pop      = 1'b0;
        unique case (state)
            S_IDLE: if (avail) begin
                state_nx = S_START;
                pop      = 1'b1;
            end
            S_START: if (bit_end) state_nx = S_DATA;
            S_DATA: if (bit_end && bit_idx == nbits - 1'b1)
                state_nx = par_en ? S_PARITY : S_STOP;
            S_PARITY: if (bit_end) state_nx = S_STOP;
            S_STOP: if (bit_end && last_stop) begin
                if (avail) begin
                    state_nx = S_START;
                    pop      = 1'b1;
                end else begin
                    state_nx = S_IDLE;
                end
            end
            default: state_nx = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_cnt <= '0;
            bit_idx  <= '0;
            shreg    <= '0;
            par_q    <= 1'b0;
            stop_q   <= 1'b0;
        end else if (pop) begin
            tick_cnt <= '0;
            bit_idx  <= '0;
            shreg    <= data;
            par_q    <= (^(data & data_mask(len))) ^ par_odd;
            stop_q   <= 1'b0;
        end else if (busy && tick) begin
            tick_cnt <= bit_end ? 5'd0 : tick_cnt + 5'd1;
            if (bit_end && state == S_DATA) begin
                shreg   <= shreg >> 1;
                bit_idx <= bit_idx + 1'b1;
            end
            if (bit_end && state == S_STOP) stop_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            S_START:  txd = 1'b0;
            S_DATA:   txd = shreg[0];
            S_PARITY: txd = par_q;
            default:  txd = 1'b1;
        endcase
    end

    p_tick_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> tick_cnt < tick_lim);
    p_load_waiting_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> state == S_START);

endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
    import uart_tx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic [1:0]        cfg_ratio,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_two_stop,
    input  logic              cfg_fifo_en,
    input  logic              cfg_irq_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              txd,
    output logic              thr_empty,
    output logic              tx_idle,
    output logic              irq
);
    logic [DATA_W-1:0] buf_data;
    logic              buf_empty, buf_full, buf_pop, shf_busy;

    uart_tx_buffer #(.DEPTH(DEPTH), .W(DATA_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .fifo_en (cfg_fifo_en),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (buf_pop),
        .rd_data (buf_data),
        .empty   (buf_empty),
        .full    (buf_full)
    );

    uart_tx_shifter u_shf (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (bit_tick),
        .ratio    (cfg_ratio),
        .len      (cfg_len),
        .par_en   (cfg_par_en),
        .par_odd  (cfg_par_odd),
        .two_stop (cfg_two_stop),
        .avail    (!buf_empty),
        .data     (buf_data),
        .pop      (buf_pop),
        .txd      (txd),
        .busy     (shf_busy)
    );

    assign thr_empty = buf_empty;
    assign tx_idle   = buf_empty && !shf_busy;
    assign irq       = cfg_irq_en && buf_empty;

    p_idle_line_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_idle |-> txd);
    p_write_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !buf_full) |=> !irq);

endmodule

// File: tb/uart_tx_core_bench.sv
module uart_tx_core_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0, rst_n = 1'b0, bit_tick = 1'b1;
    logic [1:0] cfg_ratio = 2'd0, cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0;
    logic       cfg_fifo_en = 1'b1, cfg_irq_en = 1'b0, wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       txd, thr_empty, tx_idle, irq;

    int checks = 0, fails = 0, cyc = 0, tdiv = 1;
    logic [7:0] bq [20];

    uart_tx_core u_uart_tx_core (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .cfg_ratio(cfg_ratio),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_two_stop(cfg_two_stop), .cfg_fifo_en(cfg_fifo_en), .cfg_irq_en(cfg_irq_en),
        .wr_en(wr_en), .wr_data(wr_data), .txd(txd), .thr_empty(thr_empty),
        .tx_idle(tx_idle), .irq(irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) bit_tick <= (tdiv <= 1) || (cyc % tdiv == 0);

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int ticks_of(input logic [1:0] c);
        return (c == 2'd1) ? 8 : (c == 2'd2) ? 4 : 16;
    endfunction

    function automatic int mk_frame(input logic [7:0] d, input logic [1:0] len,
                                    input bit pe, input bit po, input bit ts,
                                    output logic [11:0] f);
        int n = 1;
        bit p = 1'b0;
        f = '1;
        f[0] = 1'b0;
        for (int i = 0; i < 5 + int'(len); i++) begin
            f[n] = d[i];
            p ^= d[i];
            n++;
        end
        if (pe) begin
            f[n] = p ^ po;
            n++;
        end
        n++;
        if (ts) n++;
        return n;
    endfunction

    task automatic recv(input int nb, input int cpb, output logic [11:0] got, output int det);
        got = '1;
        do @(negedge clk); while (txd !== 1'b0);
        det = cyc;
        repeat (cpb / 2) @(negedge clk);
        got[0] = txd;
        for (int i = 1; i < nb; i++) begin
            repeat (cpb) @(negedge clk);
            got[i] = txd;
        end
    endtask

    task automatic wait_idle();
        int g = 0;
        do begin
            @(negedge clk);
            g++;
        end while (!tx_idle && g < 5000);
    endtask

    task automatic write_burst(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_en = 1'b1;
            wr_data = bq[i];
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic recv_burst(input int n, input int cpb);
        logic [11:0] exp, got;
        int nb, det, prev;
        prev = 0;
        for (int i = 0; i < n; i++) begin
            nb = mk_frame(bq[i], cfg_len, cfg_par_en, cfg_par_odd, cfg_two_stop, exp);
            recv(nb, cpb, got, det);
            chk(got == exp, "R3 R4 R5", "frame bits", got, exp);
            if (i > 0 && tdiv == 1)
                chk(det - prev == nb * cpb, "R10", "start spacing", det - prev, nb * cpb);
            prev = det;
        end
    endtask

    task automatic quiet_line(input int cycles, input string req);
        int lows = 0;
        repeat (cycles) begin
            @(negedge clk);
            if (txd !== 1'b1) lows++;
        end
        chk(lows == 0, req, "line stays high", lows, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [11:0] got;
        int det, n, zc;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(txd == 1'b1, "R1", "txd", txd, 1);
        chk(thr_empty == 1'b1, "R1", "thr_empty", thr_empty, 1);
        chk(tx_idle == 1'b1, "R1", "tx_idle", tx_idle, 1);
        chk(irq == 1'b0, "R1", "irq", irq, 0);

        // R2: start bit length with an all-ones byte, one tick per cycle
        for (int c = 0; c < 4; c++) begin
            cfg_ratio = 2'(c);
            bq[0] = 8'hFF;
            fork
                write_burst(1);
                begin
                    do @(negedge clk); while (txd !== 1'b0);
                    zc = 0;
                    while (txd === 1'b0) begin
                        zc++;
                        @(negedge clk);
                    end
                end
            join
            chk(zc == ticks_of(2'(c)), "R2", "start bit cycles", zc, ticks_of(2'(c)));
            wait_idle();
        end

        // random bursts in FIFO mode, plus two directed parity cases
        for (int t = 0; t < 12; t++) begin
            cfg_ratio = 2'($urandom_range(0, 3));
            cfg_len = 2'($urandom_range(0, 3));
            cfg_par_en = 1'($urandom_range(0, 1));
            cfg_par_odd = 1'($urandom_range(0, 1));
            cfg_two_stop = 1'($urandom_range(0, 1));
            tdiv = $urandom_range(1, 2);
            n = $urandom_range(1, 6);
            for (int i = 0; i < n; i++) bq[i] = 8'($urandom);
            if (t == 0) begin
                cfg_len = 2'd0; cfg_par_en = 1'b1; cfg_par_odd = 1'b0; bq[0] = 8'hE0;
            end
            if (t == 1) begin
                cfg_len = 2'd3; cfg_par_en = 1'b1; cfg_par_odd = 1'b1;
                cfg_two_stop = 1'b1; bq[0] = 8'h07;
            end
            fork
                write_burst(n);
                recv_burst(n, ticks_of(cfg_ratio) * tdiv);
            join
            wait_idle();
            chk(tx_idle == 1'b1 && thr_empty == 1'b1, "R9", "idle after burst", tx_idle, 1);
        end

        // R6 R8 R9 R10: overflow burst of 20 bytes, 4 ticks per bit
        tdiv = 1;
        cfg_ratio = 2'd2; cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_two_stop = 1'b0;
        for (int i = 0; i < 20; i++) bq[i] = 8'(8'h30 + i);
        fork
            begin
                write_burst(20);
                chk(thr_empty == 1'b0, "R8", "queue not empty", thr_empty, 0);
            end
            recv_burst(17, 4);
        join
        chk(thr_empty == 1'b1, "R8", "empty during last frame", thr_empty, 1);
        chk(tx_idle == 1'b0, "R9", "busy during last frame", tx_idle, 0);
        quiet_line(80, "R6");
        chk(tx_idle == 1'b1, "R9", "idle after overflow run", tx_idle, 1);

        // R7: single holding byte
        cfg_fifo_en = 1'b0;
        bq[0] = 8'hA5; bq[1] = 8'h3C;
        fork
            begin
                @(negedge clk);
                wr_en = 1'b1; wr_data = 8'hA5;
                @(negedge clk);
                wr_en = 1'b0;
                chk(thr_empty == 1'b0, "R7", "byte held", thr_empty, 0);
                @(negedge clk);
                chk(thr_empty == 1'b1, "R7", "moved to shifter", thr_empty, 1);
                wr_en = 1'b1; wr_data = 8'h3C;
                @(negedge clk);
                chk(thr_empty == 1'b0, "R7", "second byte held", thr_empty, 0);
                wr_data = 8'hF0;
                @(negedge clk);
                wr_en = 1'b0;
            end
            begin
                recv(10, 4, got, det);
                chk(got == 12'hF4A, "R7", "first frame", got, 12'hF4A);
                chk(thr_empty == 1'b0, "R7", "still held at stop", thr_empty, 0);
                recv(10, 4, got, det);
                chk(got == 12'hE78, "R7", "second frame", got, 12'hE78);
                chk(thr_empty == 1'b1, "R7", "empty after load", thr_empty, 1);
            end
        join
        quiet_line(60, "R7");

        // R11: interrupt gating
        cfg_fifo_en = 1'b1;
        @(negedge clk);
        #1 chk(irq == 1'b0, "R11", "masked", irq, 0);
        @(negedge clk);
        cfg_irq_en = 1'b1;
        #1 chk(irq == 1'b1, "R11", "enable while empty", irq, 1);
        wr_en = 1'b1; wr_data = 8'h55;
        @(negedge clk);
        wr_en = 1'b0;
        chk(irq == 1'b0, "R11", "cleared by write", irq, 0);
        @(negedge clk);
        chk(irq == 1'b1, "R11", "set after load", irq, 1);
        wait_idle();
        cfg_irq_en = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule